// File: doc/BRIEF.md
# Hierarchical Binary-Tree Barrier Network

This block joins a power-of-two array of tiles through a tree of identical two-input combining nodes. The tree is wired apart from the data network. A tile that reaches a synchronisation point raises its request line and presents a domain operand. The operand names the tree level whose subtree must gather before anyone may go on. Requests merge pairwise on the way up. The node at the named level sees both halves of its subtree arrive and turns the barrier around. A single-cycle release then fans back down to every tile under that node.

Each request picks its own scope. A domain equal to the tree height covers all tiles. Smaller values cover an aligned subgroup, and barriers in disjoint subgroups run side by side. An optional register on every inter-level link trades one cycle per level, in each direction, for shorter wires. The round trip therefore grows with the logarithm of the group size. A sticky error flag reports requests that cannot meet: two siblings that name different domains, or a domain that runs past the top of the tree.

Top module: `barrier_tree`

## Requirements
- R1: While reset is low and on the first cycle after it, every release output is 0 and the error flag is 0. Reset is the only way to clear the error flag.
- R2: A domain value d from 1 to log2(NUM_TILES) selects the group of 2^d tiles whose indices run from g*2^d to (g+1)*2^d-1. The top value selects all tiles. Each release of that group goes out only once every tile of the group has its request high with domain d.
- R3: A release is a one-cycle pulse. It reaches exactly the tiles of the completed group, and each of them still has its request high.
- R4: Count from the cycle in which the last request of a level-d group rises. The release appears 2*d cycles later with PIPE=1, and in that same cycle with PIPE=0.
- R5: Barriers in disjoint groups with different domain levels complete independently of one another, including while they overlap in time.
- R6: A tile that keeps its request high after its release does not join a new barrier. It joins again only after it lowers the request for at least one cycle and raises it once more.
- R7: Two sibling requests that meet at a node with unequal domains set the error flag. With PIPE=1, for a level-1 pair, the flag rises two cycles after the later request. Neither tile is released.
- R8: A domain of 0, or one above log2(NUM_TILES), that every tile presents is carried past the top node and sets the error flag. With PIPE=1 this happens log2(NUM_TILES)+1 cycles after the requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_TILES | Per-tile barrier request, held until released |
| dom_i | input | NUM_TILES*DOM_W | Per-tile domain level; tile t uses bits t*DOM_W upward |
| rel_o | output | NUM_TILES | Per-tile one-cycle release pulse |
| err_o | output | 1 | Sticky domain error flag |

## Verification
The assertions assume that each tile keeps its request and domain steady from the moment it raises them until its release comes back. They also assume that no tile requests while reset is low. The stimulus follows this rule. It also leaves every participant idle for a dozen cycles between rounds, so that no node is still clearing from the previous barrier. Domain conflicts are driven only between the two tiles of one level-1 pair. Out-of-range domains are driven only with every tile taking part. The reference model therefore needs no timing for the tree's internal clearing.

// File: rtl/barrier_tree_pkg.sv
package barrier_tree_pkg;

    // Width of the per-tile domain operand (levels up to 2**DOM_W-1)
    parameter int unsigned DOM_W = 3;

    // Upward token: arrival flag plus the domain it targets
    typedef struct packed {
        logic             arr;
        logic [DOM_W-1:0] dom;
    } bar_up_t;

    // Everything carried on one inter-level link
    typedef struct packed {
        bar_up_t up;
        logic    rel;
    } bar_link_t;

    typedef struct packed {
        logic busy;
        logic err;
    } node_state_t;

    typedef struct packed {
        logic hold;
    } leaf_state_t;

endpackage

// File: rtl/bar_leaf.sv
module bar_leaf
    import barrier_tree_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [DOM_W-1:0] dom_i,
    input  logic             rel_i,
    output bar_up_t          up_o,
    output logic             rel_o
);

    leaf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Once released, stay out until the tile lowers its request
        if (rel_i) st_d.hold = 1'b1;
        else if (!req_i) st_d.hold = 1'b0;
        up_o.arr = req_i & ~st_q.hold;
        up_o.dom = dom_i;
        rel_o    = rel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bar_link.sv
module bar_link
    import barrier_tree_pkg::*;
#(
    parameter bit REG = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  bar_up_t up_i,
    output bar_up_t up_o,
    input  logic    rel_i,
    output logic    rel_o
);

    bar_link_t lk_d, lk_q;

    always_comb begin
        lk_d.up  = up_i;
        lk_d.rel = rel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    // Constant select: the stage collapses to wires when REG is 0
    assign up_o  = REG ? lk_q.up  : up_i;
    assign rel_o = REG ? lk_q.rel : rel_i;

endmodule

// File: rtl/bar_node.sv
module bar_node
    import barrier_tree_pkg::*;
#(
    parameter int unsigned LEVEL     = 1,
    parameter int unsigned TOP_LEVEL = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  bar_up_t a_i,
    input  bar_up_t b_i,
    input  logic    rel_i,
    output bar_up_t up_o,
    output logic    rel_o,
    output logic    err_o
);

    localparam bit IS_TOP = (LEVEL == TOP_LEVEL);

    node_state_t st_d, st_q;
    logic both, same, hit, here, gen, fwd;

    always_comb begin
        both = a_i.arr & b_i.arr;
        same = (a_i.dom == b_i.dom);
        hit  = both & same & ~st_q.busy;
        here = (a_i.dom == DOM_W'(LEVEL));
        gen  = hit & here;
        fwd  = hit & ~here;

        rel_o    = gen | rel_i;
        up_o.arr = fwd & ~IS_TOP;
        up_o.dom = a_i.dom;

        st_d = st_q;
        // Busy masks the node from the release until both children clear
        if (rel_o)                      st_d.busy = 1'b1;
        else if (!(a_i.arr | b_i.arr))  st_d.busy = 1'b0;
        if ((both & ~same & ~st_q.busy) | (fwd & IS_TOP)) st_d.err = 1'b1;

        err_o = st_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/barrier_tree.sv
module barrier_tree
    import barrier_tree_pkg::*;
#(
    parameter int unsigned NUM_TILES = 16,
    parameter bit          PIPE      = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TILES-1:0]       req_i,
    input  logic [NUM_TILES*DOM_W-1:0] dom_i,
    output logic [NUM_TILES-1:0]       rel_o,
    output logic                       err_o
);

    localparam int unsigned LEVELS = $clog2(NUM_TILES);
    localparam int unsigned SLOTS  = 2 * NUM_TILES;

    // Heap numbering: 1 is the top node, i has children 2i and 2i+1,
    // tile t sits at NUM_TILES+t.
    bar_up_t up_src [1:SLOTS-1];
    bar_up_t up_dst [2:SLOTS-1];
    logic    dn_src [2:SLOTS-1];
    logic    dn_dst [1:SLOTS-1];
    logic [NUM_TILES-1:1] node_err;

    assign dn_dst[1] = 1'b0;

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_leaf
        bar_leaf u_leaf (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req_i[t]),
            .dom_i (dom_i[t*DOM_W +: DOM_W]),
            .rel_i (dn_dst[NUM_TILES+t]),
            .up_o  (up_src[NUM_TILES+t]),
            .rel_o (rel_o[t])
        );
    end

    for (genvar i = 2; i < SLOTS; i++) begin : g_link
        bar_link #(.REG(PIPE)) u_link (
            .clk   (clk),
            .rst_n (rst_n),
            .up_i  (up_src[i]),
            .up_o  (up_dst[i]),
            .rel_i (dn_src[i]),
            .rel_o (dn_dst[i])
        );
    end

    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_lvl
        for (genvar k = 0; k < (NUM_TILES >> lv); k++) begin : g_nd
            localparam int unsigned IDX = (NUM_TILES >> lv) + k;
            bar_node #(.LEVEL(lv), .TOP_LEVEL(LEVELS)) u_node (
                .clk   (clk),
                .rst_n (rst_n),
                .a_i   (up_dst[2*IDX]),
                .b_i   (up_dst[2*IDX+1]),
                .rel_i (dn_dst[IDX]),
                .up_o  (up_src[IDX]),
                .rel_o (dn_src[2*IDX]),
                .err_o (node_err[IDX])
            );
            assign dn_src[2*IDX+1] = dn_src[2*IDX];
        end
    end

    assign err_o = |node_err;

endmodule

// File: rtl/barrier_tree_chk.sv
module barrier_tree_chk #(
    parameter int unsigned NUM_TILES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_TILES-1:0] req_i,
    input logic [NUM_TILES-1:0] rel_o,
    input logic                 err_o
);

    // R1: the error flag is clear whenever reset is held
    a_r1_reset_clean: assert property (@(posedge clk) !rst_n |-> !err_o);

    // R3: a release only lands on a tile that is still requesting
    a_r3_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_o & ~req_i) == '0);

    // R3: no tile sees a release on two consecutive cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_o) |=> ((rel_o & $past(rel_o)) == '0));

    // R7: once raised, the error flag stays up until reset
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

bind barrier_tree barrier_tree_chk #(.NUM_TILES(NUM_TILES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .rel_o (rel_o),
    .err_o (err_o)
);

// File: tb/barrier_tree_test.sv
module barrier_tree_test;
    import barrier_tree_pkg::*;

    localparam int CLK_NS = 10;
    localparam int N      = 16;
    localparam int LV     = 4;
    localparam int PIPE   = 1;
    localparam int WD     = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N*DOM_W-1:0] dom = '0;
    logic [N-1:0] rel;
    logic err;

    barrier_tree #(.NUM_TILES(N), .PIPE(1'(PIPE))) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .dom_i(dom),
        .rel_o(rel), .err_o(err)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // Reference model: 0 idle, 1 waiting, 2 released and holding
    int st [N];
    int mdom [N];
    int sched [N];
    int relc [N];
    int err_at = -1;

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(negedge clk) begin
        logic [N-1:0] exp_rel;
        bit exp_err;
        bit all0;
        exp_rel = '0;
        if (!rst_n) begin
            for (int t = 0; t < N; t++) begin
                st[t] = 0;
                sched[t] = -1;
            end
            err_at = -1;
        end else begin
            for (int t = 0; t < N; t++)
                if (st[t] == 2 && !req[t]) st[t] = 0;
            for (int t = 0; t < N; t++)
                if (st[t] == 0 && req[t]) begin
                    st[t] = 1;
                    mdom[t] = int'(dom[t*DOM_W +: DOM_W]);
                end
            for (int d = 1; d <= LV; d++)
                for (int g = 0; g < (N >> d); g++) begin
                    bit ok;
                    ok = 1'b1;
                    for (int j = g << d; j < (g + 1) << d; j++)
                        if (!(st[j] == 1 && mdom[j] == d && sched[j] == -1)) ok = 1'b0;
                    if (ok)
                        for (int j = g << d; j < (g + 1) << d; j++)
                            sched[j] = cyc + 2 * d * PIPE;
                end
            for (int p = 0; p < N / 2; p++)
                if (st[2*p] == 1 && st[2*p+1] == 1 && mdom[2*p] != mdom[2*p+1] && err_at < 0)
                    err_at = cyc + PIPE + 1;
            all0 = 1'b1;
            for (int t = 0; t < N; t++)
                if (!(st[t] == 1 && (mdom[t] == 0 || mdom[t] > LV))) all0 = 1'b0;
            if (all0 && err_at < 0) err_at = cyc + LV * PIPE + 1;
            for (int t = 0; t < N; t++)
                if (sched[t] == cyc) begin
                    exp_rel[t] = 1'b1;
                    st[t] = 2;
                    sched[t] = -1;
                end
        end
        exp_err = (err_at >= 0 && cyc >= err_at);
        check(rel == exp_rel, tag, "release vector vs model", int'(rel), int'(exp_rel));
        check(err == exp_err, tag, "error flag vs model", int'(err), int'(exp_err));
        for (int t = 0; t < N; t++)
            if (rel[t]) relc[t] = cyc;
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic raise(int t, int d);
        req[t] = 1'b1;
        dom[t*DOM_W +: DOM_W] = DOM_W'(d);
    endtask

    task automatic clear_relc();
        for (int t = 0; t < N; t++) relc[t] = -1;
    endtask

    initial begin
        int c;
        int bad;
        clear_relc();
        step(3);
        // R1: outputs quiet under reset
        check(rel == '0, "R1", "release under reset", int'(rel), 0);
        check(err == 1'b0, "R1", "error under reset", int'(err), 0);
        rst_n = 1'b1;
        step(2);

        // R2 / R4: global barrier, tiles arrive one per cycle
        tag = "R2";
        for (int t = 0; t < N; t++) begin
            raise(t, LV);
            c = cyc;
            if (t == N - 2) begin
                step(10);
                check(relc[0] == -1, "R2", "release before last arrival", relc[0], -1);
            end else begin
                step(1);
            end
        end
        step(12);
        bad = 0;
        for (int t = 0; t < N; t++) if (relc[t] != c + 2 * LV * PIPE) bad++;
        check(bad == 0, "R4", "tiles with wrong global latency", bad, 0);
        req = '0;
        step(12);

        // R3: a level-1 pair releases only its two tiles
        tag = "R3";
        clear_relc();
        raise(4, 1);
        raise(5, 1);
        c = cyc;
        step(8);
        check(relc[4] == c + 2 * PIPE, "R3", "tile 4 release cycle", relc[4], c + 2 * PIPE);
        check(relc[5] == c + 2 * PIPE, "R3", "tile 5 release cycle", relc[5], c + 2 * PIPE);
        bad = 0;
        for (int t = 0; t < N; t++) if (t != 4 && t != 5 && relc[t] != -1) bad++;
        check(bad == 0, "R3", "tiles released outside the pair", bad, 0);
        req = '0;
        step(12);

        // R5: disjoint groups at three levels, overlapping in time
        tag = "R5";
        clear_relc();
        raise(8, 3); raise(0, 2); raise(6, 1);
        step(1);
        raise(1, 2); raise(4, 1); raise(9, 3); raise(10, 3);
        step(2);
        raise(5, 1); raise(11, 3); raise(12, 3); raise(2, 2);
        step(1);
        raise(7, 1); raise(13, 3); raise(14, 3);
        step(3);
        raise(3, 2);
        step(1);
        raise(15, 3);
        step(16);
        bad = 0;
        for (int t = 0; t < N; t++) if (relc[t] == -1) bad++;
        check(bad == 0, "R5", "tiles never released", bad, 0);
        check(relc[0] == relc[3] && relc[4] != relc[6], "R5", "group independence", relc[4], relc[6]);
        req = '0;
        step(12);

        // R6: a held request does not re-arm
        tag = "R6";
        clear_relc();
        raise(0, 1);
        raise(1, 1);
        step(8);
        check(relc[0] != -1, "R6", "first release seen", relc[0], 1);
        clear_relc();
        step(15);
        check(relc[0] == -1 && relc[1] == -1, "R6", "release while request held", relc[0], -1);
        req[0] = 1'b0;
        req[1] = 1'b0;
        step(1);
        raise(0, 1);
        raise(1, 1);
        c = cyc;
        step(8);
        check(relc[0] == c + 2 * PIPE, "R6", "re-armed release cycle", relc[0], c + 2 * PIPE);
        req = '0;
        step(12);

        // R7: sibling domain conflict, sticky until reset
        tag = "R7";
        clear_relc();
        raise(2, 1);
        raise(3, 2);
        c = cyc;
        step(1);
        check(err == 1'b0, "R7", "error one cycle after conflict", int'(err), 0);
        step(1);
        check(err == 1'b1, "R7", "error two cycles after conflict", int'(err), 1);
        step(6);
        check(relc[2] == -1 && relc[3] == -1, "R7", "conflicting tiles released", relc[2], -1);
        req = '0;
        step(6);
        check(err == 1'b1, "R7", "error after requests drop", int'(err), 1);
        rst_n = 1'b0;
        tag = "R1";
        step(2);
        check(err == 1'b0, "R1", "error cleared by reset", int'(err), 0);
        rst_n = 1'b1;
        step(3);

        // R8: out-of-range domain escapes the top node
        tag = "R8";
        for (int t = 0; t < N; t++) raise(t, 0);
        step(LV * PIPE);
        check(err == 1'b0, "R8", "error before top reached", int'(err), 0);
        step(1);
        check(err == 1'b1, "R8", "error from escaped domain", int'(err), 1);
        req = '0;
        step(3);
        rst_n = 1'b0;
        step(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule